// File: doc/BRIEF.md
# 64-bit SECDED Memory Word Codec

This block protects 64-bit memory words with 8 check bits using an odd-weight-column code. The check matrix is fixed by a per-bit table, not by binary positions. The encoder side turns a data word into its check byte, and that byte is stored next to the data. The decoder side takes a stored 72-bit codeword and works out the 8-bit syndrome. It repairs any single flipped bit, whether that bit is in the data or in the check byte. It then reports whether the word was clean, was repaired, or cannot be repaired.

Each data bit owns one 8-bit column of the check matrix. A syndrome is turned into a bit position by comparing it against every column. Each check bit owns a unit column. Every column has odd weight, so any even-weight nonzero syndrome cannot come from a single flipped bit and is reported as uncorrectable.

A parameter selects whether all outputs pass through one register stage or leave the block combinationally. The register stage is the default.

Top module: `secded_codec`

## Requirements
- R1: A codeword holds data bit i at position i (0..63) and check bit j at position 64+j (0..7).
- R2: Data bit i owns check-matrix column COL[i]. For i = 0 upward the columns are f4 f1 ec ea e9 e6 e5 e3 dc da d9 d6 d5 d3 ce cb b5 b0 ad ab a8 a7 a4 a2 9d 9b 98 97 94 92 8f 8a 75 70 6d 6b 68 67 64 62 5e 5b 58 57 54 52 4f 4a 34 31 2c 2a 29 26 25 23 1c 1a 19 16 15 13 0e 0b (hex). Check bit j owns the column with only bit j set.
- R3: Encoder check bit j is the XOR of every data bit whose column has bit j set.
- R4: A zero syndrome leaves both flags low and passes the data through unchanged.
- R5: A syndrome equal to COL[i] raises the correctable flag and returns the data with bit i inverted.
- R6: A syndrome equal to 1<<j raises the correctable flag and returns the data unchanged.
- R7: A codeword with two flipped bits raises the uncorrectable flag and passes the received data unchanged.
- R8: Syndrome 0x03 is classified as uncorrectable.
- R9: Any nonzero syndrome that is neither a data column nor a unit vector raises the uncorrectable flag and leaves the data uncorrected. This includes every even-weight syndrome.
- R10: The correctable and uncorrectable flags are never high together.
- R11: With OUT_REG=1, outputs show the result for the inputs of the previous clock edge. While reset is high, all outputs are zero.
- R12: The reported syndrome equals the check byte recomputed from the received data, XOR the received check byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rst | input | 1 | Synchronous active-high reset of the output stage |
| enc_data_i | input | 64 | Data word to encode |
| enc_chk_o | output | 8 | Check byte for enc_data_i |
| dec_code_i | input | 72 | Received codeword, check byte in bits 71:64 |
| dec_data_o | output | 64 | Corrected (or passed-through) data |
| dec_syn_o | output | 8 | Syndrome of the received codeword |
| dec_ce_o | output | 1 | Single error found and corrected |
| dec_ue_o | output | 1 | Error that cannot be corrected |

## Verification
Clean codewords built from all-zero, all-one, walking and random data confirm the encoder table and the passthrough path.

Every single data-bit flip is tried, and each one must land on its own column and repair exactly that bit. Every single check-bit flip is tried, and each one must produce a unit syndrome and leave the data untouched. Together these separate data-column hits from check-column hits.

Double flips show that even-weight syndromes are refused without altering the data, and flipping check bits 0 and 1 produces the 0x03 case. A triple flip on check bits 0, 1 and 2 gives 0x07, an odd-weight syndrome that matches no column and must also be refused.

// File: rtl/secded_pkg.sv
package secded_pkg;
    localparam int DATA_W = 64;
    localparam int CHK_W  = 8;
    localparam int CODE_W = DATA_W + CHK_W;

    typedef logic [DATA_W-1:0] data_t;
    typedef logic [CHK_W-1:0]  chk_t;

    // Stored word: check byte in the upper bits.
    typedef struct packed {
        chk_t  chk;
        data_t data;
    } code_t;

    typedef struct packed {
        data_t data;
        chk_t  syn;
        logic  ce;
        logic  ue;
    } dec_res_t;

    // Column table, data bit 0 in the least significant byte.
    localparam logic [DATA_W*CHK_W-1:0] COL_TABLE = {
        8'h0b, 8'h0e, 8'h13, 8'h15, 8'h16, 8'h19, 8'h1a, 8'h1c,
        8'h23, 8'h25, 8'h26, 8'h29, 8'h2a, 8'h2c, 8'h31, 8'h34,
        8'h4a, 8'h4f, 8'h52, 8'h54, 8'h57, 8'h58, 8'h5b, 8'h5e,
        8'h62, 8'h64, 8'h67, 8'h68, 8'h6b, 8'h6d, 8'h70, 8'h75,
        8'h8a, 8'h8f, 8'h92, 8'h94, 8'h97, 8'h98, 8'h9b, 8'h9d,
        8'ha2, 8'ha4, 8'ha7, 8'ha8, 8'hab, 8'had, 8'hb0, 8'hb5,
        8'hcb, 8'hce, 8'hd3, 8'hd5, 8'hd6, 8'hd9, 8'hda, 8'hdc,
        8'he3, 8'he5, 8'he6, 8'he9, 8'hea, 8'hec, 8'hf1, 8'hf4
    };

    function automatic chk_t col_of(input int idx);
        return COL_TABLE[idx*CHK_W +: CHK_W];
    endfunction
endpackage

// File: rtl/secded_enc.sv
module secded_enc
    import secded_pkg::*;
(
    input  data_t d_i,
    output chk_t  c_o
);
    always_comb begin
        c_o = '0;
        for (int i = 0; i < DATA_W; i++) begin
            c_o = c_o ^ (col_of(i) & {CHK_W{d_i[i]}});
        end
    end
endmodule

// File: rtl/secded_syn.sv
module secded_syn
    import secded_pkg::*;
(
    input  code_t code_i,
    output chk_t  syn_o
);
    chk_t recomputed;

    secded_enc u_regen (
        .d_i (code_i.data),
        .c_o (recomputed)
    );

    assign syn_o = recomputed ^ code_i.chk;
endmodule

// File: rtl/secded_fix.sv
module secded_fix
    import secded_pkg::*;
(
    input  data_t    d_i,
    input  chk_t     syn_i,
    output dec_res_t res_o
);
    data_t hit;
    logic  chk_hit;

    // One comparator per data column; columns are distinct, so at most one fires.
    for (genvar i = 0; i < DATA_W; i++) begin : g_col
        assign hit[i] = (syn_i == col_of(i));
    end

    assign chk_hit = (syn_i != '0) && ((syn_i & (syn_i - 1'b1)) == '0);

    always_comb begin
        res_o.syn  = syn_i;
        res_o.ce   = (|hit) || chk_hit;
        res_o.ue   = (syn_i != '0) && !((|hit) || chk_hit);
        res_o.data = d_i ^ hit;
    end
endmodule

// File: rtl/secded_codec.sv
module secded_codec
    import secded_pkg::*;
#(
    parameter bit OUT_REG = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [63:0]       enc_data_i,
    output logic [7:0]        enc_chk_o,
    input  logic [71:0]       dec_code_i,
    output logic [63:0]       dec_data_o,
    output logic [7:0]        dec_syn_o,
    output logic              dec_ce_o,
    output logic              dec_ue_o
);
    code_t    rx;
    chk_t     enc_c;
    chk_t     syn;
    dec_res_t res;

    assign rx = code_t'(dec_code_i);

    secded_enc u_enc (
        .d_i (enc_data_i),
        .c_o (enc_c)
    );

    secded_syn u_syn (
        .code_i (rx),
        .syn_o  (syn)
    );

    secded_fix u_fix (
        .d_i   (rx.data),
        .syn_i (syn),
        .res_o (res)
    );

    if (OUT_REG) begin : g_reg
        chk_t     enc_q;
        dec_res_t res_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                enc_q <= '0;
                res_q <= '0;
            end else begin
                enc_q <= enc_c;
                res_q <= res;
            end
        end
        assign enc_chk_o  = enc_q;
        assign dec_data_o = res_q.data;
        assign dec_syn_o  = res_q.syn;
        assign dec_ce_o   = res_q.ce;
        assign dec_ue_o   = res_q.ue;
    end else begin : g_comb
        assign enc_chk_o  = enc_c;
        assign dec_data_o = res.data;
        assign dec_syn_o  = res.syn;
        assign dec_ce_o   = res.ce;
        assign dec_ue_o   = res.ue;
    end
endmodule

// File: rtl/secded_codec_chk.sv
module secded_codec_chk #(
    parameter bit OUT_REG = 1'b1
) (
    input logic        clk,
    input logic        rst,
    input logic [71:0] dec_code_i,
    input logic [63:0] dec_data_o,
    input logic [7:0]  dec_syn_o,
    input logic        dec_ce_o,
    input logic        dec_ue_o
);
    logic [71:0] code_q;
    logic        armed;
    logic [63:0] ref_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            code_q <= '0;
            armed  <= 1'b0;
        end else begin
            code_q <= dec_code_i;
            armed  <= 1'b1;
        end
    end

    assign ref_data = OUT_REG ? code_q[63:0] : dec_code_i[63:0];

    // R10
    a_r10_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(dec_ce_o && dec_ue_o));

    // R4
    a_r4_clean_pass: assert property (@(posedge clk) disable iff (rst || !armed)
        (dec_syn_o == 8'h00) |-> (!dec_ce_o && !dec_ue_o && dec_data_o == ref_data));

    // R7
    a_r7_ue_untouched: assert property (@(posedge clk) disable iff (rst || !armed)
        dec_ue_o |-> (dec_data_o == ref_data));

    // R5
    a_r5_single_repair: assert property (@(posedge clk) disable iff (rst || !armed)
        dec_ce_o |-> ($countones(dec_data_o ^ ref_data) <= 1));

    // R9
    a_r9_even_weight_ue: assert property (@(posedge clk) disable iff (rst || !armed)
        ((dec_syn_o != 8'h00) && !(^dec_syn_o)) |-> dec_ue_o);

    // R8
    a_r8_syn03_ue: assert property (@(posedge clk) disable iff (rst || !armed)
        (dec_syn_o == 8'h03) |-> (dec_ue_o && !dec_ce_o));
endmodule

bind secded_codec secded_codec_chk #(.OUT_REG(OUT_REG)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .dec_code_i (dec_code_i),
    .dec_data_o (dec_data_o),
    .dec_syn_o  (dec_syn_o),
    .dec_ce_o   (dec_ce_o),
    .dec_ue_o   (dec_ue_o)
);

// File: tb/sim_secded_codec.sv
module sim_secded_codec;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] enc_data_i = '0;
    logic [7:0]  enc_chk_o;
    logic [71:0] dec_code_i = '0;
    logic [63:0] dec_data_o;
    logic [7:0]  dec_syn_o;
    logic        dec_ce_o;
    logic        dec_ue_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    secded_codec #(.OUT_REG(1'b1)) u0 (
        .clk(clk), .rst(rst),
        .enc_data_i(enc_data_i), .enc_chk_o(enc_chk_o),
        .dec_code_i(dec_code_i), .dec_data_o(dec_data_o),
        .dec_syn_o(dec_syn_o), .dec_ce_o(dec_ce_o), .dec_ue_o(dec_ue_o)
    );

    logic [7:0] COL [64] = '{
        8'hf4, 8'hf1, 8'hec, 8'hea, 8'he9, 8'he6, 8'he5, 8'he3,
        8'hdc, 8'hda, 8'hd9, 8'hd6, 8'hd5, 8'hd3, 8'hce, 8'hcb,
        8'hb5, 8'hb0, 8'had, 8'hab, 8'ha8, 8'ha7, 8'ha4, 8'ha2,
        8'h9d, 8'h9b, 8'h98, 8'h97, 8'h94, 8'h92, 8'h8f, 8'h8a,
        8'h75, 8'h70, 8'h6d, 8'h6b, 8'h68, 8'h67, 8'h64, 8'h62,
        8'h5e, 8'h5b, 8'h58, 8'h57, 8'h54, 8'h52, 8'h4f, 8'h4a,
        8'h34, 8'h31, 8'h2c, 8'h2a, 8'h29, 8'h26, 8'h25, 8'h23,
        8'h1c, 8'h1a, 8'h19, 8'h16, 8'h15, 8'h13, 8'h0e, 8'h0b
    };

    typedef struct {
        logic [7:0]  chk;
        logic [63:0] data;
        logic [7:0]  syn;
        logic        ce;
        logic        ue;
        string       tag;
    } item_t;

    item_t sb[$];

    function automatic logic [7:0] ref_enc(input logic [63:0] d);
        logic [7:0] r = '0;
        for (int i = 0; i < 64; i++) if (d[i]) r ^= COL[i];
        return r;
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Driver: apply stimulus at the falling edge and queue the expectation.
    task automatic send(input logic [63:0] d, input logic [71:0] flip, input string tag);
        item_t it;
        logic [71:0] rx;
        rx = {ref_enc(d), d} ^ flip;
        it.chk  = ref_enc(d);
        it.syn  = ref_enc(rx[63:0]) ^ rx[71:64];
        it.data = rx[63:0];
        it.ce   = 1'b0;
        it.ue   = 1'b0;
        if (it.syn != 8'h00) begin
            for (int i = 0; i < 64; i++) begin
                if (COL[i] == it.syn) begin
                    it.ce = 1'b1;
                    it.data[i] = ~it.data[i];
                end
            end
            for (int j = 0; j < 8; j++) if (it.syn == (8'h01 << j)) it.ce = 1'b1;
            it.ue = !it.ce;
        end
        it.tag = tag;
        @(negedge clk);
        enc_data_i = d;
        dec_code_i = rx;
        sb.push_back(it);
    endtask

    // Monitor: one registered result per rising edge, sampled 1 ns later.
    always @(posedge clk) begin
        #1;
        if (!rst && sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            check(it.tag, "enc_chk (R3)", 64'(enc_chk_o), 64'(it.chk));
            check(it.tag, "data", dec_data_o, it.data);
            check(it.tag, "syndrome (R12)", 64'(dec_syn_o), 64'(it.syn));
            check(it.tag, "flags (R10)", 64'({dec_ce_o, dec_ue_o}), 64'({it.ce, it.ue}));
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [63:0] rd;
        enc_data_i = 64'hdead_beef_0123_4567;
        dec_code_i = {8'hff, 64'h1};
        repeat (3) @(posedge clk);
        #1;
        // R11: outputs held at zero under reset
        check("R11", "reset enc_chk", 64'(enc_chk_o), 64'h0);
        check("R11", "reset data", dec_data_o, 64'h0);
        check("R11", "reset flags", 64'({dec_ce_o, dec_ue_o, dec_syn_o}), 64'h0);
        @(negedge clk);
        rst = 1'b0;

        // R4, R2, R3: clean words
        send(64'h0, 72'h0, "R4");
        send({64{1'b1}}, 72'h0, "R4");
        send(64'h0123_4567_89ab_cdef, 72'h0, "R3");
        for (int i = 0; i < 64; i++) send(64'h1 << i, 72'h0, "R2");
        for (int k = 0; k < 8; k++) send({$urandom, $urandom}, 72'h0, "R4");

        // R5: every data bit flipped once
        for (int i = 0; i < 64; i++) begin
            rd = {$urandom, $urandom};
            send(rd, 72'h1 << i, "R5");
        end

        // R6, R1: every check bit flipped once
        for (int j = 0; j < 8; j++) send({$urandom, $urandom}, 72'h1 << (64 + j), "R6");

        // R7: double flips in data, check and across
        send(64'h0f0f_0f0f_f0f0_f0f0, (72'h1 << 3) | (72'h1 << 40), "R7");
        send(64'h0, (72'h1 << 0) | (72'h1 << 63), "R7");
        send({$urandom, $urandom}, (72'h1 << 5) | (72'h1 << 70), "R7");
        for (int k = 0; k < 8; k++) begin
            int a = k * 7;
            send({$urandom, $urandom}, (72'h1 << a) | (72'h1 << (a + 9)), "R7");
        end

        // R8: check bits 0 and 1 flipped gives syndrome 0x03
        send(64'h5555_aaaa_5555_aaaa, (72'h1 << 64) | (72'h1 << 65), "R8");

        // R9: odd-weight syndrome 0x07 matching no column
        send(64'h1234, (72'h1 << 64) | (72'h1 << 65) | (72'h1 << 66), "R9");

        @(negedge clk);
        repeat (3) @(negedge clk);
        if (sb.size() != 0) check("R11", "pending results", 64'(sb.size()), 64'h0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule